// File: doc/BRIEF.md
# Fully Associative Translation Cache with Address-Space Tags

This block caches virtual-to-physical page translations in a small set of slots, any of which may hold any translation. A lookup presents a virtual page number, a page offset, the kind of access wanted and the identifier of the running address space. Every slot is compared at once. One cycle later the block reports exactly one of three results: a translation with the physical address, a protection fault, or a miss. Entries from several address spaces can sit side by side, because the identifier is part of the tag.

Software running in privileged mode fills the cache through a write port. A normal write picks its slot by itself. It reuses a slot that already holds the same page and address space. Failing that it takes a free slot. Failing that it evicts a victim, by least-recently-used order or by a pseudo-random sequence. A mode input chooses between the two policies. The lowest slots are reserved for pinned translations. Only an explicit pinned write changes them, and neither eviction nor flushing touches them. Two flush commands clear the other slots: one clears all of them, the other clears only those of one address space. Walking the page table after a miss happens outside this block.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid and the hit, fault and miss outputs are low. The first lookup after reset misses.
- R2: A lookup with `lk_req_i` high is sampled on a clock edge, and its result is shown during the following cycle. It hits when a valid slot matches both the page number and the current address space and its permissions allow the access. A hit gives `lk_paddr_o = {pfn, lk_off_i}` (12-bit offset) and shows the stored dirty bit.
- R3: A slot tagged with another address-space value never matches, even when the page number is equal.
- R4: Access and permission vectors both use bit 2 for read, bit 1 for write and bit 0 for execute. A matching slot that lacks a requested bit gives a fault, with the physical address and dirty outputs held at zero.
- R5: Each lookup request gives exactly one of hit, fault or miss. A cycle that follows no request shows none of them.
- R6: When `priv_i` is low, writes and flushes have no effect.
- R7: A normal write goes to the slot that already holds a valid non-pinned entry with the same page number and address space. Otherwise it goes to the lowest-numbered invalid non-pinned slot. Only when neither exists does the replacement policy choose the slot.
- R8: With `repl_mode_i` = 0, the victim is the non-pinned slot used least recently. A slot counts as used when a lookup matches it (hit or fault) or a write fills it. At reset the order from most to least recent runs from the highest slot down to slot 0.
- R9: With `repl_mode_i` = 1, the victim is slot `N_WIRED + (r mod (N_ENTRIES - N_WIRED))`. Here r is a 4-bit shift register that is seeded to 1 at reset and steps on every clock. Its next value is {r[2:0], r[3]^r[2]}.
- R10: Slots 0 to `N_WIRED-1` are pinned. Only a write with `wr_wired_i` high, addressed by `wr_wslot_i`, changes them. They are never a victim, and neither flush clears them.
- R11: A privileged `flush_all_i` invalidates every non-pinned slot.
- R12: A privileged `flush_asid_i` invalidates only the non-pinned slots whose address-space tag equals `flush_tag_i`.
- R13: In one cycle, an accepted flush cancels a write. A lookup in the same cycle as a write or flush sees the contents from before that cycle. When a write is accepted, only the written slot is marked as used, even if a lookup also matches in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_off_i | input | 12 | Lookup page offset |
| lk_acc_i | input | 3 | Requested access {read, write, execute} |
| cur_asid_i | input | 8 | Address space of the lookup |
| lk_hit_o | output | 1 | Translation succeeded |
| lk_fault_o | output | 1 | Match but access not permitted |
| lk_miss_o | output | 1 | No matching slot |
| lk_paddr_o | output | 32 | Physical address on hit, else zero |
| lk_dirty_o | output | 1 | Dirty bit of the hit slot |
| priv_i | input | 1 | Privileged mode; gates writes and flushes |
| repl_mode_i | input | 1 | 0 = least recently used, 1 = pseudo-random |
| wr_req_i | input | 1 | Write request |
| wr_wired_i | input | 1 | Write targets a pinned slot |
| wr_wslot_i | input | 1 | Pinned slot index |
| wr_vpn_i | input | 20 | Write page number |
| wr_asid_i | input | 8 | Write address-space tag |
| wr_pfn_i | input | 20 | Write frame number |
| wr_prot_i | input | 3 | Write permissions {read, write, execute} |
| wr_dirty_i | input | 1 | Write dirty bit |
| flush_all_i | input | 1 | Invalidate all non-pinned slots |
| flush_asid_i | input | 1 | Invalidate non-pinned slots of one address space |
| flush_tag_i | input | 8 | Address space to flush |

## Verification
The bench drives a lookup in the same cycle as a write, and again in the same cycle as a flush plus write. In the first case, a lookup that targets a page being rewritten must return the old frame. Both accesses race for the recency update, and only the written slot may count as used, so the cycle can also shift which slot is evicted later. A behavioural model keeps the slot contents, a recency queue and its own shift register. It applies the same-cycle order rules, and every cycle the lookup outputs must equal its prediction. Later lookup sweeps show which slot each eviction chose.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int VPN_W  = 20;
  parameter int PFN_W  = 20;
  parameter int OFF_W  = 12;
  parameter int ASID_W = 8;
  localparam int PA_W  = PFN_W + OFF_W;

  // permission / access vector: [2]=read [1]=write [0]=execute
  typedef struct packed {
    logic              vld;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic [2:0]        prot;
    logic              dirty;
  } xlat_ent_t;

  typedef enum logic {
    REPL_LRU  = 1'b0,
    REPL_RAND = 1'b1
  } repl_mode_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  xlat_ent_t         ents_i [N_ENTRIES],
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic [N_ENTRIES-1:0] hit_vec_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = ents_i[g].vld && (ents_i[g].vpn == vpn_i) &&
                          (ents_i[g].asid == asid_i);
  end
endmodule

// File: rtl/xlat_repl.sv
module xlat_repl
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int N_WIRED   = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int N_FREE   = N_ENTRIES - N_WIRED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             mode_i,
  output logic [IDX_W-1:0] vict_o
);
  function automatic logic [IDX_W-1:0] taps_f();
    case (IDX_W)
      2:       return IDX_W'(2'b11);
      3:       return IDX_W'(3'b110);
      4:       return IDX_W'(4'b1100);
      5:       return IDX_W'(5'b10100);
      6:       return IDX_W'(6'b110000);
      7:       return IDX_W'(7'b1100000);
      default: return IDX_W'(8'b10111000);
    endcase
  endfunction
  localparam logic [IDX_W-1:0] TAPS = taps_f();

  logic [IDX_W-1:0] age_q [N_ENTRIES];
  logic [IDX_W-1:0] lfsr_q;
  logic [IDX_W-1:0] lru_vict, rnd_vict;

  // ages form a permutation; 0 = most recent
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age_q[g] <= IDX_W'(N_ENTRIES - 1 - g);
      else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))              age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx_i])    age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= IDX_W'(1);
    else         lfsr_q <= {lfsr_q[IDX_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_comb begin
    lru_vict = IDX_W'(N_WIRED);
    for (int i = N_WIRED; i < N_ENTRIES; i++)
      if (age_q[i] > age_q[lru_vict]) lru_vict = IDX_W'(i);
  end

  assign rnd_vict = IDX_W'(N_WIRED + (int'(lfsr_q) % N_FREE));
  assign vict_o   = (mode_i == REPL_RAND) ? rnd_vict : lru_vict;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int N_WIRED   = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int WS_W     = (N_WIRED > 1) ? $clog2(N_WIRED) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  input  logic [2:0]        lk_acc_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              lk_hit_o,
  output logic              lk_fault_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_dirty_o,
  input  logic              priv_i,
  input  logic              repl_mode_i,
  input  logic              wr_req_i,
  input  logic              wr_wired_i,
  input  logic [WS_W-1:0]   wr_wslot_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [2:0]        wr_prot_i,
  input  logic              wr_dirty_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_tag_i
);
  xlat_ent_t ent_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] lk_match, wr_match, vld_vec;
  logic                 lk_any, same_hit, free_any;
  logic [IDX_W-1:0]     lk_idx, same_idx, free_idx, pol_vict, wr_slot;
  logic                 flush_go, wr_go, touch;
  logic [IDX_W-1:0]     touch_idx;
  xlat_ent_t            lk_ent;
  logic                 lk_perm_bad;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_vld
    assign vld_vec[g] = ent_q[g].vld;
  end

  xlat_match #(.N_ENTRIES(N_ENTRIES)) u_lk_match (
    .ents_i(ent_q), .vpn_i(lk_vpn_i), .asid_i(cur_asid_i), .hit_vec_o(lk_match)
  );
  xlat_match #(.N_ENTRIES(N_ENTRIES)) u_wr_match (
    .ents_i(ent_q), .vpn_i(wr_vpn_i), .asid_i(wr_asid_i), .hit_vec_o(wr_match)
  );

  // lowest index wins on any multi-match
  always_comb begin
    lk_any = 1'b0; lk_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) begin lk_any = 1'b1; lk_idx = IDX_W'(i); end
  end

  always_comb begin
    same_hit = 1'b0; same_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = N_ENTRIES - 1; i >= N_WIRED; i--) begin
      if (wr_match[i])     begin same_hit = 1'b1; same_idx = IDX_W'(i); end
      if (!ent_q[i].vld)   begin free_any = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  assign flush_go = priv_i & (flush_all_i | flush_asid_i);
  assign wr_go    = priv_i & wr_req_i & ~flush_go &
                    (~wr_wired_i | (int'(wr_wslot_i) < N_WIRED));

  always_comb begin
    if (wr_wired_i)    wr_slot = IDX_W'(wr_wslot_i);
    else if (same_hit) wr_slot = same_idx;
    else if (free_any) wr_slot = free_idx;
    else               wr_slot = pol_vict;
  end

  assign touch     = wr_go | (lk_req_i & lk_any);
  assign touch_idx = wr_go ? wr_slot : lk_idx;

  xlat_repl #(.N_ENTRIES(N_ENTRIES), .N_WIRED(N_WIRED)) u_repl (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch), .touch_idx_i(touch_idx),
    .mode_i(repl_mode_i), .vict_o(pol_vict)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (flush_go) begin
        if (g >= N_WIRED && (flush_all_i || ent_q[g].asid == flush_tag_i))
          ent_q[g].vld <= 1'b0;
      end else if (wr_go && wr_slot == IDX_W'(g)) begin
        ent_q[g] <= '{vld: 1'b1, vpn: wr_vpn_i, asid: wr_asid_i, pfn: wr_pfn_i,
                      prot: wr_prot_i, dirty: wr_dirty_i};
      end
    end
  end

  assign lk_ent      = ent_q[lk_idx];
  assign lk_perm_bad = |(lk_acc_i & ~lk_ent.prot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_o <= 1'b0; lk_fault_o <= 1'b0; lk_miss_o <= 1'b0;
      lk_paddr_o <= '0; lk_dirty_o <= 1'b0;
    end else begin
      lk_hit_o   <= lk_req_i & lk_any & ~lk_perm_bad;
      lk_fault_o <= lk_req_i & lk_any & lk_perm_bad;
      lk_miss_o  <= lk_req_i & ~lk_any;
      if (lk_req_i && lk_any && !lk_perm_bad) begin
        lk_paddr_o <= {lk_ent.pfn, lk_off_i};
        lk_dirty_o <= lk_ent.dirty;
      end else begin
        lk_paddr_o <= '0;
        lk_dirty_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int N_WIRED   = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lk_req_i,
  input logic [OFF_W-1:0]     lk_off_i,
  input logic                 lk_hit_o,
  input logic                 lk_fault_o,
  input logic                 lk_miss_o,
  input logic [PA_W-1:0]      lk_paddr_o,
  input logic                 priv_i,
  input logic [N_ENTRIES-1:0] vld_vec_i,
  input logic [IDX_W-1:0]     vict_i
);
  assert_one_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> $countones({lk_hit_o, lk_fault_o, lk_miss_o}) == 1);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !(lk_hit_o || lk_fault_o || lk_miss_o));

  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> (!lk_hit_o || lk_paddr_o[OFF_W-1:0] == $past(lk_off_i)));

  assert_fault_no_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_paddr_o == '0);

  assert_user_no_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |=> $stable(vld_vec_i));

  assert_pinned_stay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vld_vec_i[N_WIRED-1:0]) & ~vld_vec_i[N_WIRED-1:0]) == '0);

  assert_victim_free_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(vict_i) >= N_WIRED);
endmodule

bind xlat_cache xlat_cache_chk #(.N_ENTRIES(N_ENTRIES), .N_WIRED(N_WIRED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_off_i(lk_off_i),
  .lk_hit_o(lk_hit_o), .lk_fault_o(lk_fault_o), .lk_miss_o(lk_miss_o),
  .lk_paddr_o(lk_paddr_o), .priv_i(priv_i), .vld_vec_i(vld_vec), .vict_i(pol_vict)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  import xlat_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0; logic [VPN_W-1:0] lk_vpn = 0; logic [OFF_W-1:0] lk_off = 0;
  logic [2:0] lk_acc = 0; logic [ASID_W-1:0] cur_asid = 0;
  logic hit, fault, miss, dirty; logic [PA_W-1:0] paddr;
  logic priv = 0, mode = 0, wr_req = 0, wr_wired = 0, wr_wslot = 0, wr_dirty = 0;
  logic [VPN_W-1:0] wr_vpn = 0; logic [ASID_W-1:0] wr_asid = 0;
  logic [PFN_W-1:0] wr_pfn = 0; logic [2:0] wr_prot = 0;
  logic fl_all = 0, fl_asid = 0; logic [ASID_W-1:0] fl_tag = 0;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache #(.N_ENTRIES(N), .N_WIRED(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_off_i(lk_off),
    .lk_acc_i(lk_acc), .cur_asid_i(cur_asid), .lk_hit_o(hit), .lk_fault_o(fault),
    .lk_miss_o(miss), .lk_paddr_o(paddr), .lk_dirty_o(dirty), .priv_i(priv),
    .repl_mode_i(mode), .wr_req_i(wr_req), .wr_wired_i(wr_wired), .wr_wslot_i(wr_wslot),
    .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid), .wr_pfn_i(wr_pfn), .wr_prot_i(wr_prot),
    .wr_dirty_i(wr_dirty), .flush_all_i(fl_all), .flush_asid_i(fl_asid), .flush_tag_i(fl_tag)
  );

  // behavioural reference
  bit m_vld [N]; logic [VPN_W-1:0] m_vpn [N]; logic [ASID_W-1:0] m_asid [N];
  logic [PFN_W-1:0] m_pfn [N]; logic [2:0] m_prot [N]; bit m_dirty [N];
  int lru [$];
  logic [3:0] m_lfsr;
  bit e_hit, e_fault, e_miss, e_dirty; logic [PA_W-1:0] e_paddr;

  function automatic void touch_slot(int s);
    foreach (lru[k]) if (lru[k] == s) begin lru.delete(k); break; end
    lru.push_front(s);
  endfunction

  function automatic int lru_victim();
    for (int k = lru.size() - 1; k >= 0; k--) if (lru[k] >= W) return lru[k];
    return W;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      lru = {};
      for (int i = N - 1; i >= 0; i--) lru.push_back(i);
      m_lfsr = 4'd1;
      {e_hit, e_fault, e_miss, e_dirty} = '0; e_paddr = '0;
    end else begin
      int idx; bit fl, wg; int slot;
      idx = -1;
      for (int i = 0; i < N; i++)
        if (idx < 0 && m_vld[i] && m_vpn[i] == lk_vpn && m_asid[i] == cur_asid) idx = i;
      {e_hit, e_fault, e_miss, e_dirty} = '0; e_paddr = '0;
      if (lk_req) begin
        if (idx < 0) e_miss = 1;
        else if ((lk_acc & ~m_prot[idx]) != 0) e_fault = 1;
        else begin e_hit = 1; e_paddr = {m_pfn[idx], lk_off}; e_dirty = m_dirty[idx]; end
      end
      fl = priv && (fl_all || fl_asid);
      wg = priv && wr_req && !fl;
      if (fl) begin
        for (int i = W; i < N; i++) if (fl_all || m_asid[i] == fl_tag) m_vld[i] = 0;
        if (lk_req && idx >= 0) touch_slot(idx);
      end else if (wg) begin
        slot = -1;
        if (wr_wired) slot = int'(wr_wslot);
        else begin
          for (int i = W; i < N; i++)
            if (slot < 0 && m_vld[i] && m_vpn[i] == wr_vpn && m_asid[i] == wr_asid) slot = i;
          for (int i = W; i < N; i++) if (slot < 0 && !m_vld[i]) slot = i;
          if (slot < 0) slot = mode ? W + (int'(m_lfsr) % (N - W)) : lru_victim();
        end
        m_vld[slot] = 1; m_vpn[slot] = wr_vpn; m_asid[slot] = wr_asid;
        m_pfn[slot] = wr_pfn; m_prot[slot] = wr_prot; m_dirty[slot] = wr_dirty;
        touch_slot(slot);
      end else if (lk_req && idx >= 0) touch_slot(idx);
      m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
    end
  end

  always @(negedge clk) if (!done) begin
    n_chk++;
    if ({hit, fault, miss, dirty, paddr} !== {e_hit, e_fault, e_miss, e_dirty, e_paddr}) begin
      n_err++;
      $display("FAIL %s: got h%0b f%0b m%0b d%0b pa=%h, expected h%0b f%0b m%0b d%0b pa=%h",
               cur_req, hit, fault, miss, dirty, paddr,
               e_hit, e_fault, e_miss, e_dirty, e_paddr);
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
    lk_req = 0; wr_req = 0; wr_wired = 0; fl_all = 0; fl_asid = 0;
  endtask

  task automatic look(input int vpn, input int asid, input logic [2:0] acc);
    lk_req = 1; lk_vpn = VPN_W'(vpn); cur_asid = ASID_W'(asid);
    lk_off = OFF_W'(vpn * 37 + 5); lk_acc = acc;
  endtask

  task automatic put(input int vpn, input int asid, input int pfn, input logic [2:0] prot);
    wr_req = 1; wr_vpn = VPN_W'(vpn); wr_asid = ASID_W'(asid);
    wr_pfn = PFN_W'(pfn); wr_prot = prot; wr_dirty = pfn[0];
  endtask

  task automatic sweep(input int base, input int cnt, input int asid);
    for (int k = 0; k < cnt; k++) begin look(base + k, asid, 3'b100); tick(); end
    tick();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    look('h100, 3, 3'b100); tick(); tick();

    cur_req = "R6";
    priv = 0; put('h100, 3, 'h111, 3'b111); tick();
    fl_all = 1; tick();
    look('h100, 3, 3'b100); tick(); tick();

    cur_req = "R2";
    priv = 1; put('h12345, 3, 'hABCDE, 3'b111); tick();
    look('h12345, 3, 3'b110); tick(); tick();

    cur_req = "R3";
    look('h12345, 4, 3'b100); tick(); tick();

    cur_req = "R4";
    put('h22, 3, 'h3, 3'b100); tick();
    look('h22, 3, 3'b010); tick();
    look('h22, 3, 3'b100); tick();
    look('h22, 3, 3'b001); tick(); tick();

    cur_req = "R7";
    put('h12345, 3, 'h55, 3'b111); tick();
    look('h12345, 3, 3'b100); tick(); tick();

    cur_req = "R10";
    wr_wired = 1; wr_wslot = 0; put('h900, 1, 'h901, 3'b101); tick();
    wr_wired = 1; wr_wslot = 1; put('h902, 1, 'h903, 3'b111); tick();
    look('h900, 1, 3'b001); tick(); tick();

    cur_req = "R8";
    mode = 0;
    for (int k = 0; k < 14; k++) begin put('h200 + k, 3, 'h300 + k, 3'b111); tick(); end
    look('h203, 3, 3'b100); tick();
    look('h200, 3, 3'b100); tick();
    for (int k = 0; k < 4; k++) begin put('h400 + k, 3, 'h500 + k, 3'b110); tick(); end
    sweep('h200, 14, 3); sweep('h400, 4, 3);

    cur_req = "R13";
    look('h203, 3, 3'b100); put('h203, 3, 'h777, 3'b111); tick();
    look('h203, 3, 3'b100); tick();
    look('h200, 3, 3'b100); put('h410, 3, 'h411, 3'b111); tick();
    fl_all = 1; put('h411, 3, 'h412, 3'b111); look('h410, 3, 3'b100); tick();
    look('h410, 3, 3'b100); tick();
    look('h411, 3, 3'b100); tick(); tick();

    cur_req = "R9";
    mode = 1;
    for (int k = 0; k < 14; k++) begin put('h600 + k, 5, 'h700 + k, 3'b111); tick(); end
    for (int k = 0; k < 6; k++) begin put('h620 + k, 5, 'h720 + k, 3'b111); tick(); tick(); end
    sweep('h600, 14, 5); sweep('h620, 6, 5);

    cur_req = "R12";
    mode = 0;
    for (int k = 0; k < 5; k++) begin put('h800 + k, 9, 'h850 + k, 3'b111); tick(); end
    fl_asid = 1; fl_tag = 9; tick();
    sweep('h800, 5, 9); sweep('h600, 14, 5);

    cur_req = "R11";
    fl_all = 1; tick();
    sweep('h600, 14, 5);
    cur_req = "R10";
    look('h900, 1, 3'b100); tick();
    look('h902, 1, 3'b111); tick(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_err++;
      $display("FAIL %s: watchdog expired, got running, expected finished", cur_req);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule